// File: doc/BRIEF.md
# ISA Indirect Register Access Bridge

This block sits between an 8-bit ISA I/O slave window and a peripheral controller whose address and data travel on one shared, time-multiplexed bus. The host reaches any controller register through two ISA I/O cycles. The first cycle writes a register index to an index port on the card. The second cycle reads or writes a data port. During that second cycle the bridge replays the stored index on the shared bus under an address strobe, then runs the data phase with a read or write strobe.

The card answers only CPU I/O cycles, which have AEN low, and only when address bits 9..2 equal an 8-bit value set on switches. Address bits 1..0 pick the port inside the card. The bridge samples the ISA strobes with a local clock through a short synchronizer. A small state machine then orders the address-latch-enable pulse, a settling gap and the data strobe. The same machine controls the data buffer between the ISA lines and the card bus, and the output enable of the index register. The buffer and the index register are never enabled together.

Top module: `isa_mux_bridge`

## Requirements
- R1: `card_sel_n` is low exactly when `aen` is 0 and `isa_addr[9:2]` equals `base_sw`; it follows the pins combinationally.
- R2: Offset encodings on `isa_addr[1:0]`: 2'b00 is the index port and 2'b01 is the data port. Accesses to 2'b10 and 2'b11 are ignored. For those, `buf_en_n` stays 1, `isa_doe` and `mux_doe` stay 0, `ctl_ale` stays 0 and `ctl_cs_n` stays 1.
- R3: While an index-port write is in progress, the buffer passes data toward the card. This means `buf_en_n`=0, `buf_dir`=0, `mux_doe`=1 and `mux_dout` equal to `isa_din`, with no address strobe. The stored index takes the last byte sampled while IOW# was low and ignores data that changes after IOW# rises. The buffer turns off 3 clocks after IOW# rises.
- R4: A data-port access raises `ctl_ale` 3 clocks after the ISA strobe falls. `ctl_ale` stays high for ALE_CYCLES clocks (default 2). During that time `mux_doe`=1, `mux_dout` equals the stored index and `ctl_cs_n`=0.
- R5: After `ctl_ale` falls, the index stays on the shared bus for GAP_CYCLES clocks (default 1) with both data strobes inactive. The read or write strobe begins only after that gap.
- R6: In a data-port read, `ctl_rd_n`=0, `mux_doe`=0, `buf_en_n`=0, `buf_dir`=1 (toward ISA), `isa_doe`=1 and `isa_dout` equal to `mux_din`. All of these end 3 clocks after IOR# rises.
- R7: In a data-port write, `ctl_wr_n`=0, `mux_doe`=1, `mux_dout` equal to `isa_din`, `buf_en_n`=0 and `buf_dir`=0. These end 3 clocks after IOW# rises.
- R8: The index register output and the buffer are never enabled in the same cycle.
- R9: The stored index is unchanged by data-port accesses, so repeated data accesses present the same index.
- R10: With `aen`=1 the card does not respond, even when the address matches.
- R11: During and right after reset the stored index is 0, all controller strobes are inactive, and no bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aen | input | 1 | DMA address enable; high blocks decode |
| isa_addr | input | 10 | ISA I/O address |
| iow_n | input | 1 | ISA I/O write strobe, active low |
| ior_n | input | 1 | ISA I/O read strobe, active low |
| base_sw | input | 8 | Switch-set base address bits 9..2 |
| isa_din | input | 8 | Data from the ISA data lines |
| isa_dout | output | 8 | Data toward the ISA data lines |
| isa_doe | output | 1 | Enable for `isa_dout` onto the ISA lines |
| card_sel_n | output | 1 | Active-low card select from base decode |
| buf_en_n | output | 1 | Active-low data buffer enable |
| buf_dir | output | 1 | Buffer direction: 1 toward ISA, 0 toward card |
| mux_din | input | 8 | Data driven by the controller on the shared bus |
| mux_dout | output | 8 | Data driven by the card onto the shared bus |
| mux_doe | output | 1 | Enable for `mux_dout` onto the shared bus |
| ctl_ale | output | 1 | Address latch enable to the controller |
| ctl_cs_n | output | 1 | Controller chip select, active low |
| ctl_rd_n | output | 1 | Controller read strobe, active low |
| ctl_wr_n | output | 1 | Controller write strobe, active low |

## Verification
The card select follows the pins with no clock, so it is checked a moment after the address changes. Every other result follows a fixed clock count from the ISA strobe edge that caused it. The address strobe rises 3 clocks after the strobe falls and lasts 2 clocks. The gap lasts 1 clock, so the data strobe starts 6 clocks after the strobe falls. Each result ends 3 clocks after the ISA strobe rises. The bench drives inputs just after a rising edge and counts that many rising edges before it samples each output. It also samples one edge early at the release boundaries, to show that an output does not end too soon.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

   typedef enum logic [1:0] {
      PORT_INDEX = 2'b00,
      PORT_DATA  = 2'b01,
      PORT_SPARE = 2'b10,
      PORT_RESET = 2'b11
   } port_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_IDXW,
      ST_ALE,
      ST_GAP,
      ST_XFER
   } seq_e;

endpackage

// File: rtl/isa_bridge_decode.sv
module isa_bridge_decode #(
   parameter int ADDR_W = 10,
   localparam int BASE_W = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aen,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BASE_W-1:0] base_sw,
   output logic              sel_n,
   output logic [1:0]        port
);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("isa_bridge_decode: ADDR_W must leave at least one base bit");
      end
   endgenerate

   logic match;

   assign match = (addr[ADDR_W-1:2] == base_sw);
   assign sel_n = aen | ~match;
   assign port  = addr[1:0];

   // R10 / R1: a DMA cycle can never select the card
   a_r10_aen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      aen |-> sel_n);

endmodule

// File: rtl/isa_bridge_sync.sv
module isa_bridge_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("isa_bridge_sync: STAGES must be at least 1");
      end
      if (W < 1) begin : g_bad_w
         $error("isa_bridge_sync: W must be at least 1");
      end
   endgenerate

   generate
      if (STAGES == 1) begin : g_single
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else begin
               for (int i = 0; i < STAGES; i++) begin
                  if (i == 0) q[i] <= din;
                  else        q[i] <= q[i-1];
               end
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/isa_bridge_seq.sv
module isa_bridge_seq
   import isa_bridge_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ALE_CYCLES = 2,
   parameter int GAP_CYCLES = 1,
   localparam int MAX_CNT   = (ALE_CYCLES > GAP_CYCLES) ? ALE_CYCLES : GAP_CYCLES,
   localparam int CNT_W     = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_rd,
   input  logic              s_wr,
   input  logic              s_sel,
   input  logic [1:0]        s_port,
   input  logic [DATA_W-1:0] s_data,
   output logic              ale,
   output logic              cs,
   output logic              ctl_rd,
   output logic              ctl_wr,
   output logic              idx_oe,
   output logic              buf_en,
   output logic              buf_to_isa,
   output logic [DATA_W-1:0] idx_q
);

   generate
      if (ALE_CYCLES < 1) begin : g_bad_ale
         $error("isa_bridge_seq: ALE_CYCLES must be at least 1");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("isa_bridge_seq: GAP_CYCLES must be at least 1");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ALE_LAST = CNT_W'(ALE_CYCLES - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

   seq_e              st;
   logic [CNT_W-1:0]  cnt;
   logic              op_rd;
   logic [DATA_W-1:0] shadow;
   logic              start_idx;
   logic              start_dat;
   logic              strobe_on;

   assign start_idx = s_sel && s_wr && !s_rd && (port_e'(s_port) == PORT_INDEX);
   assign start_dat = s_sel && (s_wr ^ s_rd) && (port_e'(s_port) == PORT_DATA);
   assign strobe_on = op_rd ? s_rd : s_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         cnt    <= '0;
         op_rd  <= 1'b0;
         shadow <= '0;
         idx_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (start_idx) begin
                  shadow <= s_data;
                  st     <= ST_IDXW;
               end else if (start_dat) begin
                  op_rd <= s_rd;
                  st    <= ST_ALE;
               end
            end
            ST_IDXW: begin
               if (s_wr) begin
                  shadow <= s_data;
               end else begin
                  idx_q <= shadow;
                  st    <= ST_IDLE;
               end
            end
            ST_ALE: begin
               if (cnt == ALE_LAST) begin
                  cnt <= '0;
                  st  <= ST_GAP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_GAP: begin
               if (cnt == GAP_LAST) begin
                  cnt <= '0;
                  st  <= ST_XFER;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_XFER: begin
               if (!strobe_on) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ale        = (st == ST_ALE);
   assign idx_oe     = (st == ST_ALE) || (st == ST_GAP);
   assign cs         = (st == ST_ALE) || (st == ST_GAP) || (st == ST_XFER);
   assign ctl_rd     = (st == ST_XFER) && op_rd;
   assign ctl_wr     = (st == ST_XFER) && !op_rd;
   assign buf_en     = (st == ST_IDXW) || (st == ST_XFER);
   assign buf_to_isa = (st == ST_XFER) && op_rd;

   // R9: the index changes only when an index-port write completes
   a_r9_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDXW) |=> $stable(idx_q));

   // R4: every address phase is entered from a data-port start
   a_r4_ale_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale) |-> $past(start_dat));

   // R2: offsets other than index and data never start a sequence
   a_r2_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && s_port[1]) |=> (st == ST_IDLE));

endmodule

// File: rtl/isa_mux_bridge.sv
module isa_mux_bridge #(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ALE_CYCLES  = 2,
   parameter int GAP_CYCLES  = 1,
   localparam int BASE_W     = ADDR_W - 2,
   localparam int BUNDLE_W   = DATA_W + 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              aen,
   input  logic [ADDR_W-1:0] isa_addr,
   input  logic              iow_n,
   input  logic              ior_n,
   input  logic [BASE_W-1:0] base_sw,
   input  logic [DATA_W-1:0] isa_din,
   output logic [DATA_W-1:0] isa_dout,
   output logic              isa_doe,
   output logic              card_sel_n,
   output logic              buf_en_n,
   output logic              buf_dir,
   input  logic [DATA_W-1:0] mux_din,
   output logic [DATA_W-1:0] mux_dout,
   output logic              mux_doe,
   output logic              ctl_ale,
   output logic              ctl_cs_n,
   output logic              ctl_rd_n,
   output logic              ctl_wr_n
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("isa_mux_bridge: DATA_W must be at least 1");
      end
   endgenerate

   logic [1:0]          dec_port;
   logic [BUNDLE_W-1:0] raw_bundle;
   logic [BUNDLE_W-1:0] s_bundle;
   logic                s_rd, s_wr, s_sel;
   logic [1:0]          s_port;
   logic [DATA_W-1:0]   s_data;
   logic                ale, cs, c_rd, c_wr, idx_oe, buf_en, buf_to_isa;
   logic [DATA_W-1:0]   idx_q;

   isa_bridge_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .aen     (aen),
      .addr    (isa_addr),
      .base_sw (base_sw),
      .sel_n   (card_sel_n),
      .port    (dec_port)
   );

   assign raw_bundle = {~ior_n, ~iow_n, ~card_sel_n, dec_port, isa_din};

   isa_bridge_sync #(.W(BUNDLE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_bundle),
      .dout  (s_bundle)
   );

   assign {s_rd, s_wr, s_sel, s_port, s_data} = s_bundle;

   isa_bridge_seq #(
      .DATA_W     (DATA_W),
      .ALE_CYCLES (ALE_CYCLES),
      .GAP_CYCLES (GAP_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .s_rd       (s_rd),
      .s_wr       (s_wr),
      .s_sel      (s_sel),
      .s_port     (s_port),
      .s_data     (s_data),
      .ale        (ale),
      .cs         (cs),
      .ctl_rd     (c_rd),
      .ctl_wr     (c_wr),
      .idx_oe     (idx_oe),
      .buf_en     (buf_en),
      .buf_to_isa (buf_to_isa),
      .idx_q      (idx_q)
   );

   assign mux_dout = idx_oe ? idx_q : isa_din;
   assign mux_doe  = idx_oe | (buf_en & ~buf_to_isa);
   assign isa_dout = mux_din;
   assign isa_doe  = buf_en & buf_to_isa;
   assign buf_en_n = ~buf_en;
   assign buf_dir  = buf_to_isa;
   assign ctl_ale  = ale;
   assign ctl_cs_n = ~cs;
   assign ctl_rd_n = ~c_rd;
   assign ctl_wr_n = ~c_wr;

   // R8: index output and buffer never share the bus
   a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !(idx_oe && buf_en));

   // R5: no data strobe while the address strobe is high
   a_r5_ale_clear_of_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_ale |-> (ctl_rd_n && ctl_wr_n));

   // R5: index still presented when the address strobe falls
   a_r5_index_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_ale) |-> (mux_doe && mux_dout == idx_q && ctl_rd_n && ctl_wr_n));

   // R6: read strobe only with the return path open and the shared bus released
   a_r6_read_path: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rd_n |-> (isa_doe && !mux_doe && !ctl_cs_n));

   // R7: write strobe only with ISA data on the shared bus
   a_r7_write_path: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr_n |-> (mux_doe && !isa_doe && mux_dout == isa_din));

endmodule

// File: tb/sim_isa_mux_bridge.sv
module sim_isa_mux_bridge;

   localparam logic [7:0] BASE = 8'hC0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       aen = 1'b0;
   logic [9:0] isa_addr = '0;
   logic       iow_n = 1'b1;
   logic       ior_n = 1'b1;
   logic [7:0] base_sw = BASE;
   logic [7:0] isa_din = '0;
   logic [7:0] isa_dout;
   logic       isa_doe;
   logic       card_sel_n;
   logic       buf_en_n;
   logic       buf_dir;
   logic [7:0] mux_din = 8'h5A;
   logic [7:0] mux_dout;
   logic       mux_doe;
   logic       ctl_ale, ctl_cs_n, ctl_rd_n, ctl_wr_n;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   isa_mux_bridge u0 (
      .clk(clk), .rst_n(rst_n), .aen(aen), .isa_addr(isa_addr),
      .iow_n(iow_n), .ior_n(ior_n), .base_sw(base_sw), .isa_din(isa_din),
      .isa_dout(isa_dout), .isa_doe(isa_doe), .card_sel_n(card_sel_n),
      .buf_en_n(buf_en_n), .buf_dir(buf_dir), .mux_din(mux_din),
      .mux_dout(mux_dout), .mux_doe(mux_doe), .ctl_ale(ctl_ale),
      .ctl_cs_n(ctl_cs_n), .ctl_rd_n(ctl_rd_n), .ctl_wr_n(ctl_wr_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk_quiet(input string req);
      chk(req, "buf_en_n", buf_en_n, 1);
      chk(req, "isa_doe", isa_doe, 0);
      chk(req, "mux_doe", mux_doe, 0);
      chk(req, "ctl_ale", ctl_ale, 0);
      chk(req, "ctl_cs_n", ctl_cs_n, 1);
      chk(req, "ctl_rd_n", ctl_rd_n, 1);
      chk(req, "ctl_wr_n", ctl_wr_n, 1);
   endtask

   // R11 reset state
   task automatic t_reset();
      chk_quiet("R11");
      rst_n = 1'b1;
      tick(2);
      chk_quiet("R11");
   endtask

   // R1 card select decode
   task automatic t_decode();
      isa_addr = {BASE, 2'b01}; aen = 1'b0; #1;
      chk("R1", "sel match", card_sel_n, 0);
      isa_addr = {BASE ^ 8'h01, 2'b01}; #1;
      chk("R1", "sel mismatch", card_sel_n, 1);
      isa_addr = {BASE, 2'b01}; aen = 1'b1; #1;
      chk("R1", "sel aen", card_sel_n, 1);
      aen = 1'b0; tick(1);
   endtask

   // R3 index-port write, captured at strobe release
   task automatic t_index_write(input logic [7:0] v);
      isa_addr = {BASE, 2'b00}; isa_din = v; iow_n = 1'b0;
      tick(3);
      chk("R3", "buf_en_n", buf_en_n, 0);
      chk("R3", "buf_dir", buf_dir, 0);
      chk("R3", "mux_doe", mux_doe, 1);
      chk("R3", "mux_dout", mux_dout, v);
      chk("R3", "ctl_ale", ctl_ale, 0);
      tick(3);
      iow_n = 1'b1; isa_din = ~v;
      tick(2);
      chk("R3", "buf still on", buf_en_n, 0);
      tick(1);
      chk("R3", "buf off", buf_en_n, 1);
      chk("R3", "mux_doe off", mux_doe, 0);
      tick(2);
   endtask

   // R4 R5 R6 data-port read
   task automatic t_data_read(input logic [7:0] exp_idx, input logic [7:0] ctl_val, input string req);
      mux_din = ctl_val;
      isa_addr = {BASE, 2'b01}; ior_n = 1'b0;
      tick(2);
      chk("R4", "ale early", ctl_ale, 0);
      tick(1);
      chk("R4", "ale high", ctl_ale, 1);
      chk("R4", "cs_n", ctl_cs_n, 0);
      chk("R4", "mux_doe", mux_doe, 1);
      chk(req, "index on bus", mux_dout, exp_idx);
      chk("R8", "buf off in ale", buf_en_n, 1);
      tick(1);
      chk("R4", "ale second", ctl_ale, 1);
      tick(1);
      chk("R5", "ale low gap", ctl_ale, 0);
      chk("R5", "index in gap", mux_dout, exp_idx);
      chk("R5", "mux_doe gap", mux_doe, 1);
      chk("R5", "rd_n gap", ctl_rd_n, 1);
      tick(1);
      chk("R6", "rd_n", ctl_rd_n, 0);
      chk("R6", "mux_doe", mux_doe, 0);
      chk("R6", "buf_en_n", buf_en_n, 0);
      chk("R6", "buf_dir", buf_dir, 1);
      chk("R6", "isa_doe", isa_doe, 1);
      chk("R6", "isa_dout", isa_dout, ctl_val);
      tick(4);
      ior_n = 1'b1;
      tick(2);
      chk("R6", "rd_n held", ctl_rd_n, 0);
      tick(1);
      chk("R6", "rd_n end", ctl_rd_n, 1);
      chk("R6", "isa_doe end", isa_doe, 0);
      chk("R6", "cs_n end", ctl_cs_n, 1);
      tick(2);
   endtask

   // R7 data-port write
   task automatic t_data_write(input logic [7:0] exp_idx, input logic [7:0] v);
      isa_addr = {BASE, 2'b01}; isa_din = v; iow_n = 1'b0;
      tick(3);
      chk("R7", "ale", ctl_ale, 1);
      chk("R7", "index on bus", mux_dout, exp_idx);
      tick(2);
      chk("R7", "wr_n gap", ctl_wr_n, 1);
      tick(1);
      chk("R7", "wr_n", ctl_wr_n, 0);
      chk("R7", "mux_doe", mux_doe, 1);
      chk("R7", "mux_dout", mux_dout, v);
      chk("R7", "buf_en_n", buf_en_n, 0);
      chk("R7", "buf_dir", buf_dir, 0);
      chk("R7", "isa_doe", isa_doe, 0);
      tick(3);
      iow_n = 1'b1;
      tick(2);
      chk("R7", "wr_n held", ctl_wr_n, 0);
      tick(1);
      chk("R7", "wr_n end", ctl_wr_n, 1);
      tick(2);
   endtask

   // R2 R10: accesses that must produce no activity
   task automatic t_ignored(input logic [9:0] a, input logic a_en, input logic is_rd, input string req);
      isa_addr = a; aen = a_en; isa_din = 8'hEE;
      if (is_rd) ior_n = 1'b0; else iow_n = 1'b0;
      for (int i = 0; i < 9; i++) begin
         tick(1);
         chk_quiet(req);
      end
      ior_n = 1'b1; iow_n = 1'b1;
      tick(4);
      chk_quiet(req);
      aen = 1'b0;
   endtask

   initial begin
      tick(3);
      t_reset();
      t_decode();
      t_data_read(8'h00, 8'h11, "R11");
      t_index_write(8'h27);
      t_data_read(8'h27, 8'hA5, "R4");
      t_data_read(8'h27, 8'h3C, "R9");
      t_data_write(8'h27, 8'h96);
      t_data_read(8'h27, 8'h0F, "R9");
      t_ignored({BASE, 2'b10}, 1'b0, 1'b1, "R2");
      t_ignored({BASE, 2'b10}, 1'b0, 1'b0, "R2");
      t_ignored({BASE, 2'b11}, 1'b0, 1'b0, "R2");
      t_ignored({BASE, 2'b01}, 1'b1, 1'b1, "R10");
      t_ignored({BASE, 2'b00}, 1'b1, 1'b0, "R10");
      t_ignored({BASE ^ 8'h80, 2'b00}, 1'b0, 1'b0, "R1");
      t_data_read(8'h27, 8'hC3, "R9");
      t_index_write(8'hD4);
      t_data_write(8'hD4, 8'h01);
      t_data_read(8'hD4, 8'h7E, "R4");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule